// File: doc/BRIEF.md
# DRAM Bank Command Timing Checker

This block sits beside a DRAM command bus and audits it. Every cycle it sees
at most one command (activate, read, write, precharge of one bank, or
precharge of every bank in a rank). Each command carries a rank and a bank
number. The block keeps, for every bank, the cycles that have passed since the
last activate, read, write and precharge. For every rank it keeps the cycles
since the last precharge of any kind. It compares these against a set of
minimum spacings and reports the first broken rule as a one-cycle flag with a
cause code, the rank and the bank. It also reports commands that break the bank
protocol: a column access to a closed bank, or an activate to a bank that is
already open.

The spacings come from a 63-bit configuration word. The block latches that word
on every clock edge where the synchronous reset is high. A two-bit mode input
selects the memory family. The LPDDR modes enable the precharge-all recovery
extension and the thermal derating term, which is added to every limit while
the `hot` input is high. One low-power mode gives writes their own
activate-to-column limit. The block drives a per-bank open/closed vector. It
checks legality only and never blocks or reorders traffic.

Top module: `dram_cmd_timing_chk`

## Requirements
- R1: While `rst` is high, the block latches `cfg_word`, closes all banks and clears the flag. Changing `cfg_word` after reset has no effect. The first command to a bank after reset meets every timing rule. Field positions in `cfg_word`: derate [3:0], all-bank recovery extension [8:4], precharge-to-precharge [12:9], write-to-precharge [22:13], read-to-precharge [29:23], activate-to-precharge [38:30], activate-to-write for mode 3 [46:39], activate-to-column [54:47], precharge-to-activate [62:55].
- R2: A read or write to an open bank issued fewer than the activate-to-column cycles after that bank's activate raises cause 1. "Cycles after" is the difference between the two command cycles.
- R3: In mode 3, writes use the separate activate-to-write limit and raise cause 2, while reads keep the activate-to-column limit. In modes 0, 1 and 2, writes use the activate-to-column limit (cause 1).
- R4: A precharge or precharge-all that reaches an open bank before the activate-to-precharge limit raises cause 3.
- R5: A precharge that reaches an open bank too soon after its last write raises cause 4. One that comes too soon after its last read raises cause 5. For one bank, the priority is cause 3, then 4, then 5.
- R6: An activate too soon after the bank was closed raises cause 6. After a single-bank precharge, the limit is the precharge-to-activate value. After a precharge-all, the LPDDR modes (2 and 3) add the extension; modes 0 and 1 ignore it.
- R7: Two precharges of either kind to the same rank that are closer than the precharge-to-precharge limit raise cause 7, unless a bank-level cause applies. The rule is off in mode 1. Each rank has its own spacing.
- R8: While `hot` is high in mode 2 or 3, the derate value is added to every limit. In modes 0 and 1, `hot` is ignored.
- R9: A read or write to a closed bank raises cause 8. An activate to an open bank raises cause 9. Both take priority over the timing rules for that command.
- R10: A violation shows as `viol_valid` high for exactly the cycle after the command, with its rank, bank and cause. For a precharge-all, the bank is the lowest bank of the rank that breaks a bank rule, or the command's bank for cause 7. Cause is 0 whenever the flag is low.
- R11: A command that breaks a rule still updates the tracking state, so later checks are measured from it.
- R12: `bank_open` bit rank*BANKS_PER_RANK+bank changes in the cycle after an activate (to 1) or precharge (to 0). A precharge-all clears only its own rank. Command codes: 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all. Mode codes: 0 DDR4-like, 1 DDR5-like, 2 LPDDR4-like, 3 LPDDR5x-like.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also latches `cfg_word` |
| cfg_word | input | 63 | Timing limit word |
| cmd_mode | input | 2 | Memory family select |
| hot | input | 1 | Device temperature high |
| cmd_op | input | 3 | Command code |
| cmd_rank | input | RANK_W | Command rank |
| cmd_bank | input | BANK_W | Command bank |
| viol_valid | output | 1 | One-cycle violation flag |
| viol_rank | output | RANK_W | Rank of the violation |
| viol_bank | output | BANK_W | Bank of the violation |
| viol_cause | output | 4 | Cause code |
| bank_open | output | NUM_RANKS*BANKS_PER_RANK | Open state per bank |

## Verification
The interesting collisions are a precharge that breaks several rules at once:
activate-to-precharge, write-to-precharge and the rank's precharge-to-precharge
spacing can all fail on the same command. Precharge-all adds a second kind of
collision, where several banks of the rank fault together. The bench provokes
these by opening banks and issuing precharges only a few cycles later. A
timestamp model in the bench picks the expected cause, and it checks the
reported cause and bank against the priority order and the lowest-bank rule.
Protocol errors that coincide with a timing shortfall, such as a re-activate
right after an activate, are judged the same way.

// File: rtl/dram_chk_pkg.sv
`timescale 1ns/1ps
package dram_chk_pkg;
    localparam int CFG_W = 63;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0, OP_ACT = 3'd1, OP_RD = 3'd2, OP_WR = 3'd3,
        OP_PRE = 3'd4, OP_PREALL = 3'd5
    } dram_op_e;

    typedef enum logic [1:0] {
        MODE_DDR4 = 2'd0, MODE_DDR5 = 2'd1, MODE_LP4 = 2'd2, MODE_LP5X = 2'd3
    } dram_mode_e;

    typedef enum logic [3:0] {
        CAUSE_NONE = 4'd0, CAUSE_RCD = 4'd1, CAUSE_RCDW = 4'd2, CAUSE_RAS = 4'd3,
        CAUSE_WRPRE = 4'd4, CAUSE_RDPRE = 4'd5, CAUSE_RP = 4'd6, CAUSE_PPD = 4'd7,
        CAUSE_CLOSED = 4'd8, CAUSE_REOPEN = 4'd9
    } cause_e;

    typedef struct packed {
        logic [7:0] rp_gap;
        logic [7:0] act_col;
        logic [7:0] act_wr;
        logic [8:0] act_pre;
        logic [6:0] rd_pre;
        logic [9:0] wr_pre;
        logic [3:0] pre_pre;
        logic [4:0] all_ext;
        logic [3:0] derate;
    } tcfg_t;

    function automatic logic is_low_power(dram_mode_e m);
        return (m == MODE_LP4) || (m == MODE_LP5X);
    endfunction
endpackage

// File: rtl/dram_gap_ctr.sv
`timescale 1ns/1ps
module dram_gap_ctr #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] elapsed
);
    always_ff @(posedge clk) begin
        if (rst)                  elapsed <= '1;
        else if (restart)         elapsed <= CNT_W'(1);
        else if (elapsed != '1)   elapsed <= elapsed + CNT_W'(1);
    end

    // R11: an event restarts the gap count from one
    a_r11_restart_one: assert property (@(posedge clk) disable iff (rst)
        restart |=> elapsed == CNT_W'(1));
    // R1: a saturated gap stays saturated until the next event
    a_r1_hold_saturated: assert property (@(posedge clk) disable iff (rst)
        (elapsed == '1 && !restart) |=> elapsed == '1);
endmodule

// File: rtl/dram_bank_state.sv
`timescale 1ns/1ps
module dram_bank_state #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_act,
    input  logic             ev_rd,
    input  logic             ev_wr,
    input  logic             ev_pre,
    input  logic             ev_pall,
    output logic             is_open,
    output logic             pall_last,
    output logic [CNT_W-1:0] el_act,
    output logic [CNT_W-1:0] el_rd,
    output logic [CNT_W-1:0] el_wr,
    output logic [CNT_W-1:0] el_pre
);
    always_ff @(posedge clk) begin
        if (rst) begin
            is_open   <= 1'b0;
            pall_last <= 1'b0;
        end else begin
            if (ev_act)                 is_open <= 1'b1;
            else if (ev_pre || ev_pall) is_open <= 1'b0;
            if (ev_pre)                 pall_last <= 1'b0;
            else if (ev_pall)           pall_last <= 1'b1;
        end
    end

    dram_gap_ctr #(.CNT_W(CNT_W)) u_act (.clk(clk), .rst(rst), .restart(ev_act), .elapsed(el_act));
    dram_gap_ctr #(.CNT_W(CNT_W)) u_rd  (.clk(clk), .rst(rst), .restart(ev_rd),  .elapsed(el_rd));
    dram_gap_ctr #(.CNT_W(CNT_W)) u_wr  (.clk(clk), .rst(rst), .restart(ev_wr),  .elapsed(el_wr));
    dram_gap_ctr #(.CNT_W(CNT_W)) u_pre (.clk(clk), .rst(rst), .restart(ev_pre || ev_pall),
                                         .elapsed(el_pre));

    // R12: activate opens, any precharge closes
    a_r12_act_opens: assert property (@(posedge clk) disable iff (rst)
        ev_act |=> is_open);
    a_r12_pre_closes: assert property (@(posedge clk) disable iff (rst)
        (ev_pre || ev_pall) && !ev_act |=> !is_open);
endmodule

// File: rtl/dram_rule_eval.sv
`timescale 1ns/1ps
module dram_rule_eval
    import dram_chk_pkg::*;
#(
    parameter int NUM_RANKS      = 2,
    parameter int BANKS_PER_RANK = 8,
    parameter int CNT_W          = 12,
    localparam int RANK_W = $clog2(NUM_RANKS),
    localparam int BANK_W = $clog2(BANKS_PER_RANK),
    localparam int NBT    = NUM_RANKS * BANKS_PER_RANK
) (
    input  dram_op_e          op,
    input  logic [RANK_W-1:0] rank,
    input  logic [BANK_W-1:0] bank,
    input  dram_mode_e        mode,
    input  logic              hot,
    input  tcfg_t             cfg,
    input  logic [NBT-1:0]    open_v,
    input  logic [NBT-1:0]    pall_v,
    input  logic [CNT_W-1:0]  el_act [NBT],
    input  logic [CNT_W-1:0]  el_rd  [NBT],
    input  logic [CNT_W-1:0]  el_wr  [NBT],
    input  logic [CNT_W-1:0]  el_pre [NBT],
    input  logic [CNT_W-1:0]  el_pp  [NUM_RANKS],
    output cause_e            cause,
    output logic [BANK_W-1:0] fault_bank
);
    logic             lp;
    logic [CNT_W-1:0] der, lim_col, lim_wr, lim_ras, lim_wrpre, lim_rdpre, lim_ppd;
    logic [CNT_W-1:0] lim_rp_one, lim_rp_all;
    logic             ppd_bad;
    cause_e           pre_c [NBT];

    always_comb begin
        lp         = is_low_power(mode);
        der        = (hot && lp) ? CNT_W'(cfg.derate) : '0;
        lim_col    = CNT_W'(cfg.act_col) + der;
        lim_wr     = CNT_W'(cfg.act_wr)  + der;
        lim_ras    = CNT_W'(cfg.act_pre) + der;
        lim_wrpre  = CNT_W'(cfg.wr_pre)  + der;
        lim_rdpre  = CNT_W'(cfg.rd_pre)  + der;
        lim_ppd    = CNT_W'(cfg.pre_pre) + der;
        lim_rp_one = CNT_W'(cfg.rp_gap)  + der;
        lim_rp_all = lim_rp_one + (lp ? CNT_W'(cfg.all_ext) : '0);
        ppd_bad    = (mode != MODE_DDR5) && (el_pp[rank] < lim_ppd);

        for (int g = 0; g < NBT; g++) begin
            pre_c[g] = CAUSE_NONE;
            if (open_v[g]) begin
                if (el_act[g] < lim_ras)        pre_c[g] = CAUSE_RAS;
                else if (el_wr[g] < lim_wrpre)  pre_c[g] = CAUSE_WRPRE;
                else if (el_rd[g] < lim_rdpre)  pre_c[g] = CAUSE_RDPRE;
            end
        end

        cause      = CAUSE_NONE;
        fault_bank = bank;
        case (op)
            OP_ACT: begin
                if (open_v[{rank, bank}])
                    cause = CAUSE_REOPEN;
                else if (el_pre[{rank, bank}] < (pall_v[{rank, bank}] ? lim_rp_all : lim_rp_one))
                    cause = CAUSE_RP;
            end
            OP_RD: begin
                if (!open_v[{rank, bank}])               cause = CAUSE_CLOSED;
                else if (el_act[{rank, bank}] < lim_col) cause = CAUSE_RCD;
            end
            OP_WR: begin
                if (!open_v[{rank, bank}])               cause = CAUSE_CLOSED;
                else if (mode == MODE_LP5X) begin
                    if (el_act[{rank, bank}] < lim_wr)   cause = CAUSE_RCDW;
                end else if (el_act[{rank, bank}] < lim_col)
                    cause = CAUSE_RCD;
            end
            OP_PRE: begin
                if (pre_c[{rank, bank}] != CAUSE_NONE) cause = pre_c[{rank, bank}];
                else if (ppd_bad)                       cause = CAUSE_PPD;
            end
            OP_PREALL: begin
                for (int b = BANKS_PER_RANK - 1; b >= 0; b--) begin
                    if (pre_c[{rank, BANK_W'(b)}] != CAUSE_NONE) begin
                        cause      = pre_c[{rank, BANK_W'(b)}];
                        fault_bank = BANK_W'(b);
                    end
                end
                if (cause == CAUSE_NONE && ppd_bad) cause = CAUSE_PPD;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dram_cmd_timing_chk.sv
`timescale 1ns/1ps
module dram_cmd_timing_chk
    import dram_chk_pkg::*;
#(
    parameter int NUM_RANKS      = 2,
    parameter int BANKS_PER_RANK = 8,
    parameter int CNT_W          = 12,
    localparam int RANK_W = $clog2(NUM_RANKS),
    localparam int BANK_W = $clog2(BANKS_PER_RANK),
    localparam int NBT    = NUM_RANKS * BANKS_PER_RANK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [1:0]        cmd_mode,
    input  logic              hot,
    input  logic [2:0]        cmd_op,
    input  logic [RANK_W-1:0] cmd_rank,
    input  logic [BANK_W-1:0] cmd_bank,
    output logic              viol_valid,
    output logic [RANK_W-1:0] viol_rank,
    output logic [BANK_W-1:0] viol_bank,
    output logic [3:0]        viol_cause,
    output logic [NBT-1:0]    bank_open
);
    tcfg_t             cfg_q;
    dram_op_e          op;
    dram_mode_e        mode;
    logic [NBT-1:0]    open_v, pall_v;
    logic [CNT_W-1:0]  el_act [NBT];
    logic [CNT_W-1:0]  el_rd  [NBT];
    logic [CNT_W-1:0]  el_wr  [NBT];
    logic [CNT_W-1:0]  el_pre [NBT];
    logic [CNT_W-1:0]  el_pp  [NUM_RANKS];
    cause_e            cause;
    logic [BANK_W-1:0] fault_bank;

    assign op   = dram_op_e'(cmd_op);
    assign mode = dram_mode_e'(cmd_mode);

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= tcfg_t'(cfg_word);
    end

    for (genvar g = 0; g < NBT; g++) begin : g_bank
        localparam int RI = g / BANKS_PER_RANK;
        localparam int BI = g % BANKS_PER_RANK;
        logic in_rank, here;
        assign in_rank = (cmd_rank == RANK_W'(RI));
        assign here    = in_rank && (cmd_bank == BANK_W'(BI));
        dram_bank_state #(.CNT_W(CNT_W)) u_state (
            .clk(clk), .rst(rst),
            .ev_act (here && op == OP_ACT),
            .ev_rd  (here && op == OP_RD),
            .ev_wr  (here && op == OP_WR),
            .ev_pre (here && op == OP_PRE),
            .ev_pall(in_rank && op == OP_PREALL),
            .is_open(open_v[g]), .pall_last(pall_v[g]),
            .el_act(el_act[g]), .el_rd(el_rd[g]), .el_wr(el_wr[g]), .el_pre(el_pre[g])
        );
    end

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        dram_gap_ctr #(.CNT_W(CNT_W)) u_pp (
            .clk(clk), .rst(rst),
            .restart((op == OP_PRE || op == OP_PREALL) && cmd_rank == RANK_W'(r)),
            .elapsed(el_pp[r])
        );
    end

    dram_rule_eval #(.NUM_RANKS(NUM_RANKS), .BANKS_PER_RANK(BANKS_PER_RANK), .CNT_W(CNT_W)) u_eval (
        .op(op), .rank(cmd_rank), .bank(cmd_bank), .mode(mode), .hot(hot), .cfg(cfg_q),
        .open_v(open_v), .pall_v(pall_v), .el_act(el_act), .el_rd(el_rd), .el_wr(el_wr),
        .el_pre(el_pre), .el_pp(el_pp), .cause(cause), .fault_bank(fault_bank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_valid <= 1'b0;
            viol_rank  <= '0;
            viol_bank  <= '0;
            viol_cause <= 4'd0;
        end else begin
            viol_valid <= (cause != CAUSE_NONE);
            viol_rank  <= cmd_rank;
            viol_bank  <= fault_bank;
            viol_cause <= cause;
        end
    end

    assign bank_open = open_v;

    // R10: flag carries a nonzero cause
    a_r10_flag_has_cause: assert property (@(posedge clk) disable iff (rst)
        viol_valid |-> viol_cause != 4'd0);
    // R9: column access to a closed bank
    a_r9_closed_access: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_RD || op == OP_WR) && !bank_open[{cmd_rank, cmd_bank}])
        |=> viol_valid && viol_cause == 4'(CAUSE_CLOSED));
    // R9: activate to an open bank
    a_r9_reopen: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ACT && bank_open[{cmd_rank, cmd_bank}]) |=> viol_cause == 4'(CAUSE_REOPEN));
    // R7: no precharge spacing fault in mode 1
    a_r7_off_in_ddr5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DDR5) |=> viol_cause != 4'(CAUSE_PPD));
    // R12: precharge-all empties its rank
    a_r12_preall_rank: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PREALL) |=>
        bank_open[$past(cmd_rank) * BANKS_PER_RANK +: BANKS_PER_RANK] == '0);
endmodule

// File: tb/dram_cmd_timing_chk_test.sv
`timescale 1ns/1ps
module dram_cmd_timing_chk_test;
    localparam int NR = 2, NB = 8;
    localparam int C_RP = 4, C_COL = 5, C_WR = 7, C_RAS = 10, C_RDP = 3;
    localparam int C_WRP = 6, C_PPD = 2, C_EXT = 3, C_DER = 2;
    localparam int NEVER = -100000;

    logic        clk = 1'b0, rst = 1'b1, hot = 1'b0;
    logic [62:0] cfg_word = '0;
    logic [1:0]  cmd_mode = 2'd0;
    logic [2:0]  cmd_op = 3'd0;
    logic        cmd_rank = 1'b0;
    logic [2:0]  cmd_bank = 3'd0;
    logic        viol_valid, viol_rank;
    logic [2:0]  viol_bank;
    logic [3:0]  viol_cause;
    logic [15:0] bank_open;

    dram_cmd_timing_chk uut (.*);

    always #2.5 clk = ~clk;

    int checks = 0, failures = 0, now = 0;
    bit done = 0;
    string tag = "R1";
    int t_act [NR][NB], t_rd [NR][NB], t_wr [NR][NB], t_pre [NR][NB], t_pp [NR];
    bit opn [NR][NB], pall [NR][NB];
    bit exp_valid; int exp_cause, exp_rank, exp_bank; logic [15:0] exp_open;

    function automatic logic [62:0] good_cfg();
        return {8'(C_RP), 8'(C_COL), 8'(C_WR), 9'(C_RAS), 7'(C_RDP), 10'(C_WRP),
                4'(C_PPD), 5'(C_EXT), 4'(C_DER)};
    endfunction

    function automatic int bank_fault(int r, int b, int der);
        if (!opn[r][b]) return 0;
        if (now - t_act[r][b] < C_RAS + der) return 3;
        if (now - t_wr[r][b] < C_WRP + der) return 4;
        if (now - t_rd[r][b] < C_RDP + der) return 5;
        return 0;
    endfunction

    task automatic step(int op, int r, int b);
        int c, fb, der, lim, pf; bit lp;
        lp = (cmd_mode >= 2); der = (hot && lp) ? C_DER : 0; c = 0; fb = b;
        case (op)
            1: begin
                if (opn[r][b]) c = 9;
                else begin
                    lim = C_RP + der + ((pall[r][b] && lp) ? C_EXT : 0);
                    if (now - t_pre[r][b] < lim) c = 6;
                end
                opn[r][b] = 1; t_act[r][b] = now;
            end
            2: begin
                if (!opn[r][b]) c = 8;
                else if (now - t_act[r][b] < C_COL + der) c = 1;
                t_rd[r][b] = now;
            end
            3: begin
                if (!opn[r][b]) c = 8;
                else if (cmd_mode == 2'd3) begin if (now - t_act[r][b] < C_WR + der) c = 2; end
                else if (now - t_act[r][b] < C_COL + der) c = 1;
                t_wr[r][b] = now;
            end
            4: begin
                c = bank_fault(r, b, der);
                if (c == 0 && cmd_mode != 2'd1 && now - t_pp[r] < C_PPD + der) c = 7;
                opn[r][b] = 0; pall[r][b] = 0; t_pre[r][b] = now; t_pp[r] = now;
            end
            5: begin
                for (int bb = NB - 1; bb >= 0; bb--) begin
                    pf = bank_fault(r, bb, der);
                    if (pf != 0) begin c = pf; fb = bb; end
                end
                if (c == 0 && cmd_mode != 2'd1 && now - t_pp[r] < C_PPD + der) c = 7;
                for (int bb = 0; bb < NB; bb++) begin
                    opn[r][bb] = 0; pall[r][bb] = 1; t_pre[r][bb] = now;
                end
                t_pp[r] = now;
            end
            default: ;
        endcase
        exp_valid = (c != 0); exp_cause = c; exp_rank = r; exp_bank = fb;
        for (int rr = 0; rr < NR; rr++)
            for (int bb = 0; bb < NB; bb++) exp_open[rr*NB+bb] = opn[rr][bb];
        now++;
    endtask

    task automatic check_outputs();
        checks++;
        if (viol_valid !== exp_valid || viol_cause !== 4'(exp_cause)) begin
            failures++;
            $display("FAIL %s flag/cause got %0b/%0d exp %0b/%0d at step %0d",
                     tag, viol_valid, viol_cause, exp_valid, exp_cause, now);
        end
        if (exp_valid) begin
            checks++;
            if (viol_rank !== 1'(exp_rank) || viol_bank !== 3'(exp_bank)) begin
                failures++;
                $display("FAIL %s R10 rank/bank got %0d/%0d exp %0d/%0d",
                         tag, viol_rank, viol_bank, exp_rank, exp_bank);
            end
        end
        checks++;
        if (bank_open !== exp_open) begin
            failures++;
            $display("FAIL %s R12 bank_open got %h exp %h", tag, bank_open, exp_open);
        end
    endtask

    task automatic issue(int op, int r, int b);
        check_outputs();
        step(op, r, b);
        cmd_op = 3'(op); cmd_rank = 1'(r); cmd_bank = 3'(b);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) issue(0, 0, 0);
    endtask

    task automatic restart(int m);
        @(negedge clk);
        rst = 1'b1; cmd_op = 3'd0; cmd_mode = 2'(m); hot = 1'b0; cfg_word = good_cfg();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < NR; r++) begin
            t_pp[r] = NEVER;
            for (int b = 0; b < NB; b++) begin
                t_act[r][b] = NEVER; t_rd[r][b] = NEVER; t_wr[r][b] = NEVER;
                t_pre[r][b] = NEVER; opn[r][b] = 0; pall[r][b] = 0;
            end
        end
        exp_valid = 0; exp_cause = 0; exp_open = '0; now = 0;
    endtask

    initial begin
        restart(0);
        tag = "R1"; cfg_word = '0;          // later words must be ignored
        idle(2);
        issue(1, 1, 6); idle(1);            // first activate after reset is legal
        tag = "R2"; issue(1, 0, 0); idle(3); issue(2, 0, 0);
        issue(1, 0, 1); idle(4); issue(2, 0, 1); issue(3, 0, 1);
        tag = "R9"; issue(2, 0, 2); issue(3, 1, 7); issue(1, 0, 0);
        tag = "R11"; issue(2, 0, 0); idle(5); issue(2, 0, 0);
        tag = "R4"; issue(1, 1, 3); idle(3); issue(3, 1, 3); idle(4); issue(4, 1, 3);
        tag = "R6"; issue(1, 1, 3); idle(10);
        tag = "R5"; issue(1, 1, 4); idle(5); issue(3, 1, 4); idle(3); issue(4, 1, 4);
        idle(3); issue(1, 1, 5); idle(8); issue(2, 1, 5); issue(4, 1, 5);
        tag = "R6"; issue(1, 1, 5); idle(2); issue(1, 1, 4);
        tag = "R7"; idle(4); issue(4, 0, 5); issue(4, 0, 6); issue(4, 1, 6); idle(2); issue(4, 0, 4);
        tag = "R10"; issue(1, 0, 2); issue(1, 0, 3); idle(2); issue(5, 0, 7);
        tag = "R6"; issue(1, 0, 2); idle(2); issue(1, 0, 3);
        tag = "R8"; hot = 1'b1; issue(1, 1, 0); idle(4); issue(2, 1, 0); hot = 1'b0;
        tag = "R3"; issue(1, 1, 1); idle(4); issue(3, 1, 1); idle(2);

        restart(1);
        tag = "R7"; idle(1); issue(4, 0, 0); issue(4, 0, 1); issue(5, 0, 2); idle(2);

        restart(2);
        tag = "R6"; issue(1, 0, 0); idle(10); issue(5, 0, 0); idle(4); issue(1, 0, 0);
        idle(1); issue(1, 0, 1); idle(2);
        tag = "R8"; hot = 1'b1; issue(1, 1, 0); idle(5); issue(2, 1, 0); issue(2, 1, 0);
        idle(3); issue(4, 1, 0); issue(4, 1, 1); hot = 1'b0;
        tag = "R3"; issue(1, 1, 2); idle(4); issue(3, 1, 2); idle(2);

        restart(3);
        tag = "R3"; issue(1, 0, 0); idle(4); issue(2, 0, 0); issue(3, 0, 0); issue(3, 0, 0);
        issue(1, 0, 1); idle(4); issue(3, 0, 1); idle(2);
        tag = "R10"; issue(1, 1, 4); issue(1, 1, 6); idle(10); issue(3, 1, 6); issue(5, 1, 0); idle(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 run did not end got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule